// File: doc/BRIEF.md
# Write-Through Direct-Mapped Cache Controller

This block is a small direct-mapped cache. It sits between a processor and a single-port main memory that runs on a clock four times slower than the cache clock. The processor issues one-word read or write requests. The cache answers a read with a one-cycle valid strobe, and it raises a busy flag while it serves a request. On the memory side the cache drives an address, a read/write select, write data and a chip select. It then waits for a read-done or write-done handshake from the memory.

The cache writes through to memory and does not allocate a line on a write. A read miss refills the whole line. The refill is four single-word memory reads at the aligned block, one read per handshake. The refilled line then serves the requested word. A write hit updates the cached word and also writes that word to memory. A write miss goes to memory only. The done handshakes come from the slow domain, so each one passes through a two-flop synchronizer and an edge detector before the controller acts on it.

Top module: `wtc_cache`

## Requirements
- R1: An 8-bit address splits into tag = addr[7:4], line = addr[3:2] and word = addr[1:0]. Four lines each hold one tag and four 32-bit words. Two addresses with the same line index and different tags evict each other.
- R2: After reset every line is invalid, so the first read of any address is a miss. During reset busy_o, rvalid_o and mem_cs_o are low.
- R3: A read whose line is valid and whose tag matches returns the addressed word on rdata_o with rvalid_o. It makes no memory access.
- R4: A read miss makes exactly four memory reads, at {tag,line,0}, {tag,line,1}, {tag,line,2} and {tag,line,3} in that order. The cache then stores the tag and all four words in the line and returns the requested word with rvalid_o.
- R5: A write hit updates the cached word and makes exactly one memory write of the same address and data. A later read of that address hits and returns the new data.
- R6: A write miss makes exactly one memory write and leaves the cache unchanged. A later read of that address is still a miss.
- R7: rd_i = 1 requests a read and rd_i = 0 requests a write. mem_rd_o = 1 marks a memory read and mem_rd_o = 0 marks a memory write.
- R8: mem_cs_o is high only while a memory transfer is outstanding, and never while busy_o is low.
- R9: A request seen with busy_o low is accepted, and busy_o is high on the next cycle. busy_o stays high until the request completes. Requests presented while busy_o is high are ignored.
- R10: While mem_cs_o stays high, mem_addr_o and mem_rd_o hold steady. Each done pulse is taken once, however many cache cycles it stays high.
- R11: rvalid_o is a single-cycle pulse, one per read, in the cycle busy_o falls. Writes produce no rvalid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Cache and processor clock |
| rst_ni | input | 1 | Active-low reset, sampled on clk_i |
| req_i | input | 1 | Request strobe from the processor |
| rd_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 8 | Request word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data strobe |
| busy_o | output | 1 | Request in progress |
| mem_cs_o | output | 1 | Memory chip select |
| mem_rd_o | output | 1 | 1 = memory read, 0 = memory write |
| mem_addr_o | output | 8 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data |
| mem_rd_done_i | input | 1 | Memory read completed (slow domain) |
| mem_wr_done_i | input | 1 | Memory write completed (slow domain) |

## Verification
The bench keeps its own valid/tag model and watches every memory operation. It checks hit and miss, and the memory traffic, for reads and writes at several addresses. A design that refills in the wrong order or at an unaligned base would show up in the logged read addresses. A design that skips the cached-word update on a write hit would return stale data on the next read hit, and one that allocated on a write miss would skip the refill the bench expects. Two addresses that share a line check eviction. A request held up during a refill checks that requests are ignored while busy: a design that accepted it would log an extra memory write. The slow memory holds each done pulse for four cache cycles, so a design that acted on the level and not the edge would capture too many words.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_RD_REQ, ST_RD_GAP, ST_FILL, ST_WR_REQ
  } wtc_state_e;
endpackage

// File: rtl/wtc_done_sync.sv
module wtc_done_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [2:0] sh_q;
  always_ff @(posedge clk_i) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[1:0], d_i};
  end
  assign rise_o = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/wtc_store.sv
module wtc_store #(
  parameter int TAG_W     = 4,
  parameter int LINE_BITS = 2,
  parameter int WORD_BITS = 2,
  parameter int DATA_W    = 32,
  localparam int LINES    = 1 << LINE_BITS,
  localparam int WORDS    = 1 << WORD_BITS
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [TAG_W-1:0]                 tag_i,
  input  logic [LINE_BITS-1:0]             line_i,
  input  logic [WORD_BITS-1:0]             word_i,
  output logic                             hit_o,
  output logic [DATA_W-1:0]                word_o,
  input  logic                             wr_en_i,
  input  logic [DATA_W-1:0]                wr_data_i,
  input  logic                             fill_en_i,
  input  logic [WORDS-1:0][DATA_W-1:0]     fill_data_i
);
  logic [LINES-1:0]                         valid_all;
  logic [LINES-1:0][TAG_W-1:0]              tag_all;
  logic [LINES-1:0][WORDS-1:0][DATA_W-1:0]  data_all;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic                          sel;
    logic                          valid_q;
    logic [TAG_W-1:0]              tag_q;
    logic [WORDS-1:0][DATA_W-1:0]  data_q;
    assign sel = (line_i == LINE_BITS'(g));

    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        valid_q <= 1'b0;
        tag_q   <= '0;
      end else if (fill_en_i && sel) begin
        valid_q <= 1'b1;
        tag_q   <= tag_i;
      end
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_word
      always_ff @(posedge clk_i) begin
        if (fill_en_i && sel)
          data_q[w] <= fill_data_i[w];
        else if (wr_en_i && sel && word_i == WORD_BITS'(w))
          data_q[w] <= wr_data_i;
      end
    end

    assign valid_all[g] = valid_q;
    assign tag_all[g]   = tag_q;
    assign data_all[g]  = data_q;
  end

  assign hit_o  = valid_all[line_i] && (tag_all[line_i] == tag_i);
  assign word_o = data_all[line_i][word_i];
endmodule

// File: rtl/wtc_cache.sv
module wtc_cache
  import wtc_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int LINE_BITS = 2,
  parameter int WORD_BITS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              busy_o,
  output logic              mem_cs_o,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_rd_done_i,
  input  logic              mem_wr_done_i
);
  localparam int TAG_W = ADDR_W - LINE_BITS - WORD_BITS;
  localparam int WORDS = 1 << WORD_BITS;

  wtc_state_e               state_q;
  logic [ADDR_W-1:0]        addr_q;
  logic                     rd_q;
  logic [DATA_W-1:0]        wdata_q;
  logic [WORD_BITS-1:0]     cnt_q;
  logic [WORDS-1:0][DATA_W-1:0] buf_q;
  logic [DATA_W-1:0]        rdata_q;
  logic                     rvalid_q;

  logic [TAG_W-1:0]     tag_w;
  logic [LINE_BITS-1:0] line_w;
  logic [WORD_BITS-1:0] word_w;
  logic                 hit, rd_rise, wr_rise, st_wr, st_fill;
  logic [DATA_W-1:0]    hit_word;

  assign tag_w  = addr_q[ADDR_W-1 -: TAG_W];
  assign line_w = addr_q[WORD_BITS +: LINE_BITS];
  assign word_w = addr_q[WORD_BITS-1:0];

  wtc_done_sync u_rd_sync (.clk_i, .rst_ni, .d_i(mem_rd_done_i), .rise_o(rd_rise));
  wtc_done_sync u_wr_sync (.clk_i, .rst_ni, .d_i(mem_wr_done_i), .rise_o(wr_rise));

  assign st_wr   = (state_q == ST_CHECK) && !rd_q && hit;
  assign st_fill = (state_q == ST_FILL);

  wtc_store #(
    .TAG_W(TAG_W), .LINE_BITS(LINE_BITS), .WORD_BITS(WORD_BITS), .DATA_W(DATA_W)
  ) u_store (
    .clk_i, .rst_ni,
    .tag_i(tag_w), .line_i(line_w), .word_i(word_w),
    .hit_o(hit), .word_o(hit_word),
    .wr_en_i(st_wr), .wr_data_i(wdata_q),
    .fill_en_i(st_fill), .fill_data_i(buf_q)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      rd_q     <= 1'b1;
      wdata_q  <= '0;
      cnt_q    <= '0;
      buf_q    <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          addr_q  <= addr_i;
          rd_q    <= rd_i;
          wdata_q <= wdata_i;
          state_q <= ST_CHECK;
        end
        ST_CHECK: begin
          cnt_q <= '0;
          if (!rd_q)    state_q <= ST_WR_REQ;
          else if (hit) begin
            rdata_q  <= hit_word;
            rvalid_q <= 1'b1;
            state_q  <= ST_IDLE;
          end else      state_q <= ST_RD_REQ;
        end
        ST_RD_REQ: if (rd_rise) begin
          buf_q[cnt_q] <= mem_rdata_i;
          if (cnt_q == WORD_BITS'(WORDS - 1)) state_q <= ST_FILL;
          else begin
            cnt_q   <= cnt_q + 1'b1;
            state_q <= ST_RD_GAP;
          end
        end
        ST_RD_GAP: state_q <= ST_RD_REQ;
        ST_FILL: begin
          rdata_q  <= buf_q[word_w];
          rvalid_q <= 1'b1;
          state_q  <= ST_IDLE;
        end
        ST_WR_REQ: if (wr_rise) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign rdata_o     = rdata_q;
  assign rvalid_o    = rvalid_q;
  assign mem_cs_o    = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
  assign mem_rd_o    = (state_q != ST_WR_REQ);
  assign mem_addr_o  = (state_q == ST_WR_REQ) ? addr_q : {tag_w, line_w, cnt_q};
  assign mem_wdata_o = wdata_q;
endmodule

// File: rtl/wtc_cache_chk.sv
module wtc_cache_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              busy_o,
  input logic              rvalid_o,
  input logic              mem_cs_o,
  input logic              mem_rd_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  assert_cs_in_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_cs_o |-> busy_o);

  assert_accept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o) |=> busy_o);

  assert_mem_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_cs_o && $past(mem_cs_o)) |-> ($stable(mem_addr_o) && $stable(mem_rd_o)));

  assert_rvalid_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

  assert_rvalid_at_end_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> (!busy_o && $past(busy_o)));
endmodule

bind wtc_cache wtc_cache_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/wtc_cache_test.sv
module wtc_cache_test;
  logic        clk = 1'b0, mclk = 1'b0, rst_ni = 1'b0;
  logic        req_i = 1'b0, rd_i = 1'b1;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o, mem_wdata_o, mem_rdata_i;
  logic        rvalid_o, busy_o, mem_cs_o, mem_rd_o;
  logic [7:0]  mem_addr_o;
  logic        mrd_done, mwr_done;

  int total = 0, fails = 0, rv_cnt = 0;
  logic [31:0] mem [256];
  int          op_addr[$];
  bit          op_wr[$];
  logic [31:0] op_data[$];
  bit          m_valid[4];
  int          m_tag[4];

  always #10 clk = ~clk;                       // 50 MHz
  initial begin #5; forever #40 mclk = ~mclk; end  // four times slower

  wtc_cache uut (
    .clk_i(clk), .rst_ni, .req_i, .rd_i, .addr_i, .wdata_i,
    .rdata_o, .rvalid_o, .busy_o, .mem_cs_o, .mem_rd_o, .mem_addr_o,
    .mem_wdata_o, .mem_rdata_i, .mem_rd_done_i(mrd_done), .mem_wr_done_i(mwr_done)
  );

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 + i * 3;
    mrd_done = 1'b0; mwr_done = 1'b0; mem_rdata_i = '0;
  end

  // slow single-port memory, one op per handshake, done held one memory cycle
  always @(posedge mclk) begin
    if (mem_cs_o && !mrd_done && !mwr_done) begin
      op_addr.push_back(int'(mem_addr_o));
      op_wr.push_back(!mem_rd_o);
      op_data.push_back(mem_wdata_o);
      if (mem_rd_o) begin
        mem_rdata_i <= mem[mem_addr_o];
        mrd_done    <= 1'b1;
      end else begin
        mem[mem_addr_o] = mem_wdata_o;
        mwr_done       <= 1'b1;
      end
    end else begin
      mrd_done <= 1'b0;
      mwr_done <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the reference protocol
  always @(negedge clk) if (rst_ni) begin
    if (rvalid_o) rv_cnt++;
    chk(busy_o || !mem_cs_o, "R8", "cs while idle", mem_cs_o, 0);
  end

  task automatic do_req(input bit rd, input logic [7:0] a, input logic [31:0] d,
                        input bit intrude);
    int  base = op_addr.size();
    int  ln   = int'(a[3:2]);
    bit  hit  = m_valid[ln] && (m_tag[ln] == int'(a[7:4]));
    logic [31:0] keep10 = mem[8'h10];
    rv_cnt = 0;
    @(negedge clk);
    req_i = 1'b1; rd_i = rd; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 1'b0;
    chk(busy_o === 1'b1, "R9", "busy after accept", busy_o, 1);
    if (intrude) begin
      repeat (3) @(negedge clk);
      req_i = 1'b1; rd_i = 1'b0; addr_i = 8'h10; wdata_i = 32'hBAD0_BAD0;
      @(negedge clk);
      req_i = 1'b0;
    end
    while (busy_o) @(negedge clk);
    @(negedge clk);
    if (rd) begin
      chk(rv_cnt == 1, "R11", "rvalid count", rv_cnt, 1);
      chk(rdata_o === mem[a], hit ? "R3" : "R4", "read data", rdata_o, mem[a]);
      if (hit)
        chk(op_addr.size() == base, "R3", "hit mem ops", op_addr.size() - base, 0);
      else begin
        chk(op_addr.size() == base + 4, "R4", "refill op count", op_addr.size() - base, 4);
        for (int k = 0; k < 4; k++) if (base + k < op_addr.size()) begin
          chk(op_addr[base+k] == int'({a[7:2], 2'(k)}), "R4", "refill addr",
              op_addr[base+k], {a[7:2], 2'(k)});
          chk(!op_wr[base+k], "R7", "refill op is read", op_wr[base+k], 0);
        end
        m_valid[ln] = 1'b1;
        m_tag[ln]   = int'(a[7:4]);
      end
    end else begin
      chk(rv_cnt == 0, "R11", "no rvalid on write", rv_cnt, 0);
      chk(op_addr.size() == base + 1, hit ? "R5" : "R6", "write op count",
          op_addr.size() - base, 1);
      if (op_addr.size() > base) begin
        chk(op_wr[base] && op_addr[base] == int'(a), "R7", "write op addr", op_addr[base], a);
        chk(op_data[base] === d, hit ? "R5" : "R6", "write data", op_data[base], d);
      end
    end
    if (intrude)
      chk(mem[8'h10] === keep10, "R9", "request while busy ignored", mem[8'h10], keep10);
    chk(!busy_o, "R9", "busy released", busy_o, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(!busy_o && !rvalid_o && !mem_cs_o, "R2", "reset outputs",
        {busy_o, rvalid_o, mem_cs_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    // R6: write misses go to memory only
    for (int i = 0; i < 4; i++) do_req(1'b0, 8'h78 + 8'(i), 32'd56 + i, 1'b0);
    // R2/R4: first read misses and refills line 2
    do_req(1'b1, 8'h78, '0, 1'b0);
    // R3: read hit
    do_req(1'b1, 8'h7A, '0, 1'b0);
    // R5: write hit, then hit returns new data
    do_req(1'b0, 8'h7A, 32'd60, 1'b0);
    do_req(1'b1, 8'h7A, '0, 1'b0);
    // R1: same line, other tag evicts
    do_req(1'b1, 8'h3A, '0, 1'b0);
    do_req(1'b1, 8'h7B, '0, 1'b0);
    // R4: unaligned word in another line
    do_req(1'b1, 8'hF5, '0, 1'b0);
    do_req(1'b1, 8'hF7, '0, 1'b0);
    // R6: write miss leaves no allocation
    do_req(1'b0, 8'h01, 32'h1234_5678, 1'b0);
    do_req(1'b1, 8'h01, '0, 1'b0);
    // R9/R10: request during refill ignored, done level taken once
    do_req(1'b1, 8'hB6, '0, 1'b1);
    do_req(1'b1, 8'hB4, '0, 1'b0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule